// File: doc/BRIEF.md
# Move Instruction Execute Unit

This block executes one kind of instruction: a move into a 32-bit register file with sixteen entries. Each instruction word comes with a one-bit form select. In register form, the value is read from a source register. In immediate form, the value is a constant built from a 12-bit field: an 8-bit byte is rotated right by an even amount.

The move is predicated on a 4-bit condition code, which is tested against the current N and Z flags. When the condition holds, the value is written to the destination register. If the set-flags bit is also high, N and Z are updated from the value. When the condition fails, neither the register nor the flags change.

The unit is a two-stage pipeline built around a register file with synchronous reads, so it maps onto FPGA block RAM. A registered debug read port shows the contents of any register. One instruction may be issued per clock, and back-to-back dependent instructions see each other's results.

Top module: `mov_exec_unit`

## Requirements
- R1: Instruction fields sit at fixed bit positions: condition at [31:28], set-flags at [20], destination at [15:12], source register at [3:0], and immediate at [11:0]. Within the immediate, the rotate count is [11:8] and the byte is [7:0]. `form_imm` = 0 selects register form and 1 selects immediate form. Bits [27:21] and [19:16] are ignored, as are bits [11:4] in register form.
- R2: A register-form move copies all 32 bits of the source register into the destination register.
- R3: An immediate-form move zero-extends the byte and rotates it right by twice the rotate count. Bits leaving bit 0 re-enter at bit 31. For example, field 0xC01 gives 0x00000100.
- R4: An executed move with set-flags = 1 loads N from bit 31 of the moved value, and sets Z exactly when that value is zero.
- R5: An executed move with set-flags = 0 leaves N and Z unchanged.
- R6: Condition codes behave as follows:
  - 0000 executes when Z = 1.
  - 0001 executes when Z = 0.
  - 0100 executes when N = 1.
  - 0101 executes when N = 0.
  - 1110 always executes.
  - Every other code never executes.
- R7: A move whose condition fails changes no register and no flag, whatever its set-flags bit.
- R8: An instruction issued in the clock right after another sees that earlier instruction's register write and flag update.
- R9: An instruction sampled with `instr_valid` at clock edge k is reported at edge k+1 by `done_valid`, with `done_exec` high exactly when it executed. Its register write and flag update also take effect at edge k+1.
- R10: Synchronous reset clears N, Z, `done_valid` and `done_exec`. It also discards an instruction in flight without writing its register.
- R11: `dbg_data` returns the contents of register `dbg_addr` as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction present this cycle |
| form_imm | input | 1 | 0 = register source, 1 = immediate source |
| instr | input | 32 | Instruction word |
| dbg_addr | input | 4 | Register index for the debug read |
| dbg_data | output | 32 | Registered contents of the addressed register |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| done_valid | output | 1 | An instruction completed at the last edge |
| done_exec | output | 1 | That instruction passed its condition |

## Verification
The following properties are checked on every cycle:
- Completion timing.
- Flags holding when no update is made.
- N tracking the sign of the moved value.
- Failed instructions leaving the flags alone.
- Unsupported codes never executing.
- The always code always executing.

The value written into the register file can only be shown by the bench's scenarios, which read registers back over the debug port. These scenarios cover:
- A sweep over all 4096 immediate fields.
- All 256 source and destination pairs.
- Every condition code against each reachable flag state.
- Back-to-back dependencies.
- Reset arriving with an instruction in flight.

// File: rtl/mov_pkg.sv
package mov_pkg;

  // Condition code encodings tested against N and Z
  localparam logic [3:0] CC_EQ = 4'b0000;
  localparam logic [3:0] CC_NE = 4'b0001;
  localparam logic [3:0] CC_MI = 4'b0100;
  localparam logic [3:0] CC_PL = 4'b0101;
  localparam logic [3:0] CC_AL = 4'b1110;

  // Instruction field positions
  localparam int COND_LSB = 28;
  localparam int SETF_BIT = 20;
  localparam int RD_LSB   = 12;
  localparam int RM_LSB   = 0;

  // Fields fully decoded from one instruction
  typedef struct packed {
    logic [3:0]  cond;
    logic        set_flags;
    logic [3:0]  rd;
    logic [3:0]  rm;
    logic [11:0] imm12;
    logic        use_imm;
  } mov_dec_t;

  // Fields carried into the execute stage
  typedef struct packed {
    logic [3:0]  cond;
    logic        set_flags;
    logic [3:0]  rd;
    logic [11:0] imm12;
    logic        use_imm;
  } mov_exe_t;

endpackage

// File: rtl/mov_decode.sv
module mov_decode
  import mov_pkg::*;
(
  input  logic [31:0] instr,
  input  logic        form_imm,
  output mov_dec_t    dec
);

  // Opcode-space bits carry no meaning for this unit
  logic unused_bits;
  assign unused_bits = ^{instr[27:21], instr[19:16]};

  always_comb begin
    dec.cond      = instr[COND_LSB +: 4];
    dec.set_flags = instr[SETF_BIT];
    dec.rd        = instr[RD_LSB +: 4];
    dec.rm        = instr[RM_LSB +: 4];
    dec.imm12     = instr[11:0];
    dec.use_imm   = form_imm;
  end

endmodule

// File: rtl/mov_imm_expand.sv
module mov_imm_expand #(
  parameter int DATA_W = 32
) (
  input  logic [11:0]       imm12,
  output logic [DATA_W-1:0] value
);

  logic [DATA_W-1:0] base;
  logic [4:0]        amt;
  int                back;

  always_comb begin
    base  = {{(DATA_W-8){1'b0}}, imm12[7:0]};
    amt   = {imm12[11:8], 1'b0};
    back  = DATA_W - int'(amt);
    // A shift by DATA_W yields zero, so amt = 0 leaves base as is
    value = (base >> amt) | (base << back);
  end

endmodule

// File: rtl/mov_cond_check.sv
module mov_cond_check
  import mov_pkg::*;
(
  input  logic [3:0] cond,
  input  logic       flag_n,
  input  logic       flag_z,
  output logic       pass
);

  always_comb begin
    unique case (cond)
      CC_EQ:   pass = flag_z;
      CC_NE:   pass = !flag_z;
      CC_MI:   pass = flag_n;
      CC_PL:   pass = !flag_n;
      CC_AL:   pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end

endmodule

// File: rtl/mov_regfile.sv
module mov_regfile #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_b
);

  // No reset: the array stays inferable as block RAM
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end

endmodule

// File: rtl/mov_exec_unit.sv
module mov_exec_unit
  import mov_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREGS  = 16,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic              form_imm,
  input  logic [31:0]       instr,
  input  logic [AW-1:0]     dbg_addr,
  output logic [DATA_W-1:0] dbg_data,
  output logic              flag_n,
  output logic              flag_z,
  output logic              done_valid,
  output logic              done_exec
);

  mov_dec_t          dec;
  mov_exe_t          s1_exe;
  logic              s1_valid;
  logic              s1_byp;
  logic [DATA_W-1:0] s1_byp_data;
  logic [DATA_W-1:0] rf_rd;
  logic [DATA_W-1:0] imm_val;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] res;
  logic              cond_pass;
  logic              rf_we;
  logic              flag_we;

  // Stage 1: decode and synchronous source read
  mov_decode u_dec (
    .instr    (instr),
    .form_imm (form_imm),
    .dec      (dec)
  );

  mov_regfile #(.DATA_W(DATA_W), .DEPTH(NREGS)) u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (AW'(s1_exe.rd)),
    .wdata   (res),
    .raddr_a (AW'(dec.rm)),
    .rdata_a (rf_rd),
    .raddr_b (dbg_addr),
    .rdata_b (dbg_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_byp   <= 1'b0;
    end else begin
      s1_valid <= instr_valid;
      // Capture a write landing in the same edge as this source read
      s1_byp   <= rf_we && (s1_exe.rd == dec.rm);
    end
    s1_exe.cond      <= dec.cond;
    s1_exe.set_flags <= dec.set_flags;
    s1_exe.rd        <= dec.rd;
    s1_exe.imm12     <= dec.imm12;
    s1_exe.use_imm   <= dec.use_imm;
    s1_byp_data      <= res;
  end

  // Stage 2: operand select, condition, write-back
  mov_imm_expand #(.DATA_W(DATA_W)) u_imm (
    .imm12 (s1_exe.imm12),
    .value (imm_val)
  );

  mov_cond_check u_cc (
    .cond   (s1_exe.cond),
    .flag_n (flag_n),
    .flag_z (flag_z),
    .pass   (cond_pass)
  );

  always_comb begin
    operand = s1_byp ? s1_byp_data : rf_rd;
    res     = s1_exe.use_imm ? imm_val : operand;
    rf_we   = s1_valid && cond_pass && !rst;
    flag_we = rf_we && s1_exe.set_flags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_n     <= 1'b0;
      flag_z     <= 1'b0;
      done_valid <= 1'b0;
      done_exec  <= 1'b0;
    end else begin
      if (flag_we) begin
        flag_n <= res[DATA_W-1];
        flag_z <= (res == '0);
      end
      done_valid <= s1_valid;
      done_exec  <= rf_we;
    end
  end

endmodule

// File: rtl/mov_exec_unit_chk.sv
module mov_exec_unit_chk
  import mov_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              s1_valid,
  input logic [3:0]        s1_cond,
  input logic              flag_we,
  input logic [DATA_W-1:0] res,
  input logic              flag_n,
  input logic              flag_z,
  input logic              done_valid,
  input logic              done_exec
);

  // R9: completion reported one edge after the execute stage holds an instruction
  p_done_timing_r9: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> $past(s1_valid));

  p_exec_implies_done_r9: assert property (@(posedge clk) disable iff (rst)
    done_exec |-> done_valid);

  // R5: flags stay put when no update is made
  p_flags_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable({flag_n, flag_z}));

  // R4: N follows the sign of the moved value
  p_n_sign_r4: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> (flag_n == $past(res[DATA_W-1])));

  // R7: a failed instruction leaves the flags alone
  p_fail_keeps_flags_r7: assert property (@(posedge clk) disable iff (rst)
    (done_valid && !done_exec) |-> $stable({flag_n, flag_z}));

  // R6: unsupported codes never execute, the always code always does
  p_bad_cond_r6: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !(s1_cond == CC_EQ || s1_cond == CC_NE || s1_cond == CC_MI ||
                   s1_cond == CC_PL || s1_cond == CC_AL)) |=> !done_exec);

  p_always_r6: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_cond == CC_AL) |=> done_exec);

endmodule

bind mov_exec_unit mov_exec_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .s1_valid   (s1_valid),
  .s1_cond    (s1_exe.cond),
  .flag_we    (flag_we),
  .res        (res),
  .flag_n     (flag_n),
  .flag_z     (flag_z),
  .done_valid (done_valid),
  .done_exec  (done_exec)
);

// File: tb/mov_exec_unit_tb.sv
module mov_exec_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        instr_valid;
  logic        form_imm;
  logic [31:0] instr;
  logic [3:0]  dbg_addr;
  logic [31:0] dbg_data;
  logic        flag_n, flag_z, done_valid, done_exec;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] m_reg [16];
  logic        m_n, m_z;

  always #5 clk = ~clk;

  mov_exec_unit u_dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .form_imm(form_imm),
    .instr(instr), .dbg_addr(dbg_addr), .dbg_data(dbg_data),
    .flag_n(flag_n), .flag_z(flag_z), .done_valid(done_valid), .done_exec(done_exec)
  );

  function automatic logic [31:0] exp_imm(input logic [11:0] f);
    logic [31:0] v;
    v = {24'd0, f[7:0]};
    for (int i = 0; i < 2 * int'(f[11:8]); i++) v = {v[0], v[31:1]};
    return v;
  endfunction

  function automatic bit cond_ok(input logic [3:0] c, input logic n, input logic z);
    case (c)
      4'b0000: return z;
      4'b0001: return !z;
      4'b0100: return n;
      4'b0101: return !n;
      4'b1110: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] enc(input logic [3:0] c, input bit s,
                                      input logic [3:0] rd, input logic [11:0] low,
                                      input bit junk);
    return {c, junk ? 7'h7F : 7'h00, s, junk ? 4'hF : 4'h0, rd, low};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_mov(input logic [3:0] c, input bit s, input logic [3:0] rd,
                        input logic [11:0] fld, input bit imm, input bit junk,
                        input string tag);
    logic [31:0] val;
    bit ok;
    val = imm ? exp_imm(fld) : m_reg[fld[3:0]];
    ok  = cond_ok(c, m_n, m_z);
    @(negedge clk);
    instr_valid = 1'b1;
    form_imm    = imm;
    instr       = enc(c, s, rd, imm ? fld : {junk ? 8'hFF : 8'h00, fld[3:0]}, junk);
    @(negedge clk);
    instr_valid = 1'b0;
    instr       = '0;
    @(negedge clk);
    chk({"R9 done_valid ", tag}, {31'd0, done_valid}, 32'd1);
    chk({"R6 done_exec ", tag}, {31'd0, done_exec}, {31'd0, ok});
    if (ok) begin
      m_reg[rd] = val;
      if (s) begin
        m_n = val[31];
        m_z = (val == 32'd0);
      end
    end
    chk({(ok && s) ? "R4 flags " : (ok ? "R5 flags " : "R7 flags "), tag},
        {30'd0, flag_n, flag_z}, {30'd0, m_n, m_z});
  endtask

  task automatic read_reg(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    dbg_addr = a;
    @(negedge clk);
    v = dbg_data;
  endtask

  task automatic chk_reg(input logic [3:0] a, input string tag);
    logic [31:0] v;
    read_reg(a, v);
    chk(tag, v, m_reg[a]);
  endtask

  initial begin
    #(1_000_000ns);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; instr_valid = 1'b0; form_imm = 1'b0; instr = '0; dbg_addr = '0;
    m_n = 1'b0; m_z = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk("R10 reset flags", {30'd0, flag_n, flag_z}, 32'd0);
    chk("R10 reset done", {30'd0, done_valid, done_exec}, 32'd0);

    // R3 worked example
    do_mov(4'b1110, 1'b1, 4'd1, 12'hC01, 1'b1, 1'b0, "R3 example");
    read_reg(4'd1, v);
    chk("R3 example 0xC01", v, 32'h0000_0100);

    // R3/R4: every immediate field, with flags set
    for (int i = 0; i < 4096; i++) begin
      do_mov(4'b1110, 1'b1, 4'(i), 12'(i), 1'b1, i[0], "R3 sweep");
      chk_reg(4'(i), "R3 R11 imm value");
    end

    // R2/R1/R5: all source/destination pairs, ignored bits set, alternating S
    for (int sr = 0; sr < 16; sr++) begin
      for (int ds = 0; ds < 16; ds++) begin
        do_mov(4'b1110, ds[0], 4'(ds), 12'(sr), 1'b0, 1'b1, "R2 R1 reg pair");
        chk_reg(4'(ds), "R2 R1 reg copy");
      end
    end

    // R6/R7: every code against each reachable flag state
    for (int st = 0; st < 3; st++) begin
      for (int c = 0; c < 16; c++) begin
        do_mov(4'b1110, 1'b1, 4'd0,
               (st == 0) ? 12'h000 : ((st == 1) ? 12'h102 : 12'h001),
               1'b1, 1'b0, "R6 setup");
        do_mov(4'b1110, 1'b0, 4'd5, 12'h03C, 1'b1, 1'b0, "R5 marker");
        do_mov(4'(c), 1'b1, 4'd5, (st == 0) ? 12'h0FF : 12'h000, 1'b1, 1'b0, "R6 R7 cond");
        chk_reg(4'd5, "R7 cond write");
      end
    end

    // R8: back-to-back dependency on register and flags
    @(negedge clk);
    instr_valid = 1'b1; form_imm = 1'b1; instr = enc(4'b1110, 1'b1, 4'd2, 12'h4AB, 1'b0);
    @(negedge clk);
    form_imm = 1'b0; instr = enc(4'b1110, 1'b0, 4'd3, 12'h002, 1'b0);
    @(negedge clk);
    form_imm = 1'b1; instr = enc(4'b0100, 1'b0, 4'd4, 12'h011, 1'b0);
    @(negedge clk);
    instr_valid = 1'b0; instr = '0;
    m_reg[2] = 32'hAB00_0000; m_reg[3] = 32'hAB00_0000; m_reg[4] = 32'h11;
    m_n = 1'b1; m_z = 1'b0;
    @(negedge clk);
    chk("R8 flags", {30'd0, flag_n, flag_z}, {30'd0, m_n, m_z});
    chk_reg(4'd3, "R8 forwarded register");
    chk_reg(4'd4, "R8 forwarded flags");

    // R10: reset with an instruction in flight
    do_mov(4'b1110, 1'b1, 4'd7, 12'h055, 1'b1, 1'b0, "R10 pre");
    @(negedge clk);
    instr_valid = 1'b1; form_imm = 1'b1; instr = enc(4'b1110, 1'b1, 4'd7, 12'h1AA, 1'b0);
    @(negedge clk);
    instr_valid = 1'b0; instr = '0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    m_n = 1'b0; m_z = 1'b0;
    chk("R10 flags cleared", {30'd0, flag_n, flag_z}, 32'd0);
    chk("R10 done cleared", {30'd0, done_valid, done_exec}, 32'd0);
    chk_reg(4'd7, "R10 in-flight dropped");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule